// File: doc/BRIEF.md
# Interrupt and Control Input Conditioner

This block sits between the asynchronous control pins of a small processor core and the core's sequencer. It brings the maskable interrupt request, the non-maskable interrupt, the active-low wait-test input and the external reset request into the core clock domain. At every instruction boundary it decides whether the core must enter an interrupt acknowledge sequence, and it reports the vector type to use.

The sequencer marks the final clock of each instruction with `insn_last_i`. It drives the current interrupt-enable flag on `int_en_i`, raises `wait_active_i` while a wait instruction executes, and pulses `int_ack_i` when it has accepted an interrupt. The block answers with `take_int_o` and `int_type_o` in that same cycle, with `wait_stall_o` to hold the core idle, and with `core_reset_o`, a reset that has been qualified by its length.

Top module: `intr_cond`

## Requirements
- R1: Every asynchronous input (`irq_i`, `nmi_i`, `test_ni`, `rst_req_i`) passes through two flip-flops. A change set up before clock edge k is seen by the decision logic from edge k+1 on.
- R2: `take_int_o` is high only in a cycle where `insn_last_i` is high. In such a cycle it is high, with no added delay, when an NMI is pending or when the synchronised request is high and `int_en_i` is high, and `core_reset_o` is low.
- R3: While `int_en_i` is low, the maskable request alone never raises `take_int_o`.
- R4: A low-to-high transition of the synchronised `nmi_i` sets a pending flag on the following edge. At a boundary, a pending NMI is taken whatever the value of `int_en_i`, and `int_type_o` reads 2.
- R5: When an NMI and the maskable request are both active at a boundary, the NMI wins and `int_type_o` is 2.
- R6: Holding `nmi_i` high creates no new request after the first one has been acknowledged. Only a fresh rising edge sets the flag again.
- R7: Once set, the NMI pending flag stays set across boundaries until an edge sees `int_ack_i` high.
- R8: A take that is caused only by the maskable request drives `int_type_o` to 0, because the type is supplied later by the acknowledge cycle. `int_type_o` is 0 whenever `take_int_o` is low.
- R9: `wait_stall_o` is high exactly when `wait_active_i` is high, the synchronised `test_ni` is high and `core_reset_o` is low.
- R10: `core_reset_o` rises after the synchronised reset request has been sampled high on 4 consecutive edges. A request that is sampled high on fewer edges has no effect.
- R11: `core_reset_o` falls on the first edge that samples the synchronised request low. While it is high, `take_int_o` and `wait_stall_o` are held low and the NMI pending flag is cleared.
- R12: While `rst_ni` is low, `core_reset_o` is high, `take_int_o` and `wait_stall_o` are low, `int_type_o` is 0 and no NMI is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| irq_i | input | 1 | Maskable interrupt request, asynchronous, active high level |
| nmi_i | input | 1 | Non-maskable interrupt, asynchronous, rising-edge |
| test_ni | input | 1 | Wait-test input, asynchronous, active low |
| rst_req_i | input | 1 | External reset request, asynchronous, active high |
| int_en_i | input | 1 | Interrupt-enable flag from the core |
| insn_last_i | input | 1 | High in the last clock of an instruction |
| wait_active_i | input | 1 | A wait instruction is executing |
| int_ack_i | input | 1 | Core has accepted the interrupt |
| take_int_o | output | 1 | Enter the acknowledge sequence at this boundary |
| int_type_o | output | 8 | Vector type: 2 for NMI, 0 for maskable |
| wait_stall_o | output | 1 | Hold the core idle |
| core_reset_o | output | 1 | Qualified core reset |

## Verification
The hardest case to reach is the reset qualifier's threshold. The synchronised request must stay high for exactly three and then exactly four consecutive edges, and random pin toggling seldom produces such clean runs. The bench therefore drives directed pulses of both lengths and counts the cycles in which `core_reset_o` is high. Random traffic draws reset requests as runs of random length, so runs close to the threshold also occur while interrupts are arriving. A directed sequence also holds `nmi_i` high across an acknowledge, with interrupts disabled, to show that only a fresh edge re-arms the flag.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int TYPE_W       = 8;
  localparam int NMI_TYPE     = 2;
  localparam int SYNC_STAGES  = 2;
  localparam int RST_MIN_CYC  = 4;
  localparam int N_ASYNC      = 4;
  // bit positions in the synchroniser bundle
  localparam int B_IRQ  = 0;
  localparam int B_NMI  = 1;
  localparam int B_TEST = 2;
  localparam int B_RST  = 3;
  typedef logic [TYPE_W-1:0] int_type_t;
endpackage

// File: rtl/icc_sync.sv
module icc_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/icc_rst_qual.sv
module icc_rst_qual #(
  parameter int MIN_CYC = 4,
  localparam int CNT_W  = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  output logic core_rst_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             core_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      core_rst_q <= 1'b1;
    end else if (!req_s_i) begin
      cnt_q      <= '0;
      core_rst_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      core_rst_q <= (cnt_q == CNT_TOP);
    end
  end

  assign core_rst_o = core_rst_q;

  AST_RST_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_q) |-> $past(req_s_i)) else $error("reset without request"); // R10
  AST_RST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_s_i |=> !core_rst_q) else $error("reset held after request dropped"); // R11
endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter
  import icc_pkg::*;
#(
  parameter int NMI_VEC = NMI_TYPE
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      irq_s_i,
  input  logic      nmi_s_i,
  input  logic      int_en_i,
  input  logic      insn_last_i,
  input  logic      int_ack_i,
  input  logic      core_rst_i,
  output logic      take_int_o,
  output int_type_t int_type_o
);
  logic nmi_prev_q;
  logic nmi_pend_q;
  logic nmi_edge;
  logic irq_ok;

  assign nmi_edge = nmi_s_i & ~nmi_prev_q;
  assign irq_ok   = irq_s_i & int_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_s_i;
      if (core_rst_i)     nmi_pend_q <= 1'b0;
      else if (nmi_edge)  nmi_pend_q <= 1'b1;
      else if (int_ack_i) nmi_pend_q <= 1'b0;
    end
  end

  // NMI outranks the maskable request
  always_comb begin
    take_int_o = 1'b0;
    int_type_o = '0;
    if (insn_last_i && !core_rst_i) begin
      if (nmi_pend_q) begin
        take_int_o = 1'b1;
        int_type_o = int_type_t'(NMI_VEC);
      end else if (irq_ok) begin
        take_int_o = 1'b1;
      end
    end
  end

  AST_NMI_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(nmi_s_i) && !core_rst_i) |=> nmi_pend_q) else $error("nmi edge lost"); // R4
  AST_NMI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !int_ack_i && !core_rst_i) |=> nmi_pend_q) else $error("nmi dropped"); // R7
  AST_MASKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_int_o && !nmi_pend_q) |-> int_en_i) else $error("masked irq taken"); // R3
  AST_TAKE_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_int_o |-> (insn_last_i && !core_rst_i)) else $error("take off boundary"); // R2
endmodule

// File: rtl/intr_cond.sv
module intr_cond
  import icc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       nmi_i,
  input  logic       test_ni,
  input  logic       rst_req_i,
  input  logic       int_en_i,
  input  logic       insn_last_i,
  input  logic       wait_active_i,
  input  logic       int_ack_i,
  output logic       take_int_o,
  output logic [7:0] int_type_o,
  output logic       wait_stall_o,
  output logic       core_reset_o
);
  localparam logic [N_ASYNC-1:0] SYNC_RST = N_ASYNC'(1) << B_TEST; // test idles inactive (high)

  logic [N_ASYNC-1:0] async_d, sync_q;
  logic               core_rst;
  int_type_t          type_w;

  always_comb begin
    async_d         = '0;
    async_d[B_IRQ]  = irq_i;
    async_d[B_NMI]  = nmi_i;
    async_d[B_TEST] = test_ni;
    async_d[B_RST]  = rst_req_i;
  end

  icc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_d),
    .q_o   (sync_q)
  );

  icc_rst_qual #(.MIN_CYC(RST_MIN_CYC)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_s_i   (sync_q[B_RST]),
    .core_rst_o(core_rst)
  );

  icc_arbiter #(.NMI_VEC(NMI_TYPE)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_s_i    (sync_q[B_IRQ]),
    .nmi_s_i    (sync_q[B_NMI]),
    .int_en_i   (int_en_i),
    .insn_last_i(insn_last_i),
    .int_ack_i  (int_ack_i),
    .core_rst_i (core_rst),
    .take_int_o (take_int_o),
    .int_type_o (type_w)
  );

  assign int_type_o   = type_w;
  assign wait_stall_o = wait_active_i & sync_q[B_TEST] & ~core_rst;
  assign core_reset_o = core_rst;

  AST_STALL_ON_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_stall_o |-> (sync_q[B_TEST] && !core_reset_o)) else $error("stall with test low"); // R9
  AST_QUIET_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_o |-> (!take_int_o && !wait_stall_o)) else $error("activity in reset"); // R11
  AST_TYPE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_int_o |-> (int_type_o == 8'd0)) else $error("type without take"); // R8
endmodule

// File: tb/intr_cond_test.sv
`timescale 1ns/1ps
module intr_cond_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 0, nmi = 0, test_n = 1, rst_req = 0, ien = 0, last = 0, wact = 0, ack = 0;
  logic take, stall, crst;
  logic [7:0] ityp;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_cond uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi), .test_ni(test_n),
    .rst_req_i(rst_req), .int_en_i(ien), .insn_last_i(last), .wait_active_i(wact),
    .int_ack_i(ack), .take_int_o(take), .int_type_o(ityp), .wait_stall_o(stall),
    .core_reset_o(crst)
  );

  // reference model built from the requirements
  logic [1:0] m_irq, m_nmi, m_test, m_rst;
  logic m_prev, m_pend, m_crst;
  int   m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq <= 0; m_nmi <= 0; m_test <= 2'b11; m_rst <= 0;
      m_prev <= 0; m_pend <= 0; m_crst <= 1; m_cnt <= 0;
    end else begin
      m_irq  <= {m_irq[0], irq};
      m_nmi  <= {m_nmi[0], nmi};
      m_test <= {m_test[0], test_n};
      m_rst  <= {m_rst[0], rst_req};
      m_prev <= m_nmi[1];
      if (m_crst) m_pend <= 0;
      else if (m_nmi[1] && !m_prev) m_pend <= 1;
      else if (ack) m_pend <= 0;
      if (!m_rst[1]) begin m_cnt <= 0; m_crst <= 0; end
      else begin
        if (m_cnt < 3) m_cnt <= m_cnt + 1;
        m_crst <= (m_cnt == 3);
      end
    end
  end

  function automatic logic exp_take();
    return last && !m_crst && (m_pend || (m_irq[1] && ien));
  endfunction
  function automatic logic [7:0] exp_type();
    return (exp_take() && m_pend) ? 8'd2 : 8'd0;
  endfunction
  function automatic logic exp_stall();
    return wact && m_test[1] && !m_crst;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    chk("R2 take_int", take, exp_take());
    chk("R4 int_type", ityp, exp_type());
    chk("R9 wait_stall", stall, exp_stall());
    chk("R10 core_reset", crst, m_crst);
  endtask

  task automatic step();
    @(negedge clk);
    model_cmp();
  endtask

  task automatic quiet();
    irq = 0; nmi = 0; test_n = 1; rst_req = 0; ien = 0; last = 0; wact = 0; ack = 0;
  endtask

  initial begin
    int run;
    void'($urandom(32'd20240611));
    quiet();
    // R12: reset state with inputs that would otherwise act
    last = 1; wact = 1; irq = 1; ien = 1;
    #1;
    repeat (3) @(negedge clk);
    chk("R12 core_reset", crst, 1'b1);
    chk("R12 take_int", take, 1'b0);
    chk("R12 wait_stall", stall, 1'b0);
    chk("R12 int_type", ityp, 8'd0);
    quiet();
    rst_n = 1;
    repeat (4) step();

    // R1: test input seen after two edges
    wact = 1; test_n = 1;
    repeat (3) step();
    test_n = 0;
    step(); chk("R1 stall after one edge", stall, 1'b1);
    step(); chk("R1 stall after two edges", stall, 1'b0);
    test_n = 1; repeat (2) step();
    chk("R9 stall with test high", stall, 1'b1);
    wact = 0; step();
    chk("R9 no stall outside wait", stall, 1'b0);

    // R3: masked request ignored
    irq = 1; ien = 0; repeat (3) step();
    last = 1; step(); chk("R3 masked irq", take, 1'b0);
    ien = 1; step(); chk("R8 maskable take", take, 1'b1);
    chk("R8 maskable type", ityp, 8'd0);
    last = 0; irq = 0; ien = 0; repeat (3) step();

    // R4/R7/R6: NMI edge with interrupts disabled, held level
    nmi = 1; repeat (3) step();
    last = 1; step();
    chk("R4 nmi take", take, 1'b1);
    chk("R4 nmi type", ityp, 8'd2);
    step(); chk("R7 nmi still pending", take, 1'b1);
    last = 0; ack = 1; step();
    ack = 0; last = 1; step();
    chk("R6 no retrigger on held nmi", take, 1'b0);
    last = 0; nmi = 0; repeat (3) step();

    // R5: both active, NMI first, then maskable after ack
    irq = 1; ien = 1; nmi = 1; repeat (3) step();
    last = 1; step();
    chk("R5 nmi priority", ityp, 8'd2);
    last = 0; ack = 1; step();
    ack = 0; last = 1; step();
    chk("R8 irq after nmi ack take", take, 1'b1);
    chk("R8 irq after nmi ack type", ityp, 8'd0);
    quiet(); repeat (4) step();

    // R10: three-edge pulse ignored, four-edge pulse qualifies
    begin
      int hi;
      rst_req = 1; repeat (3) step(); rst_req = 0;
      hi = 0;
      repeat (10) begin step(); if (crst) hi++; end
      chk("R10 short pulse ignored", hi, 0);
      rst_req = 1; repeat (4) step(); rst_req = 0;
      hi = 0;
      repeat (10) begin step(); if (crst) hi++; end
      chk("R11 reset high one cycle", hi, 1);
    end

    // R11: NMI pending cleared by qualified reset
    nmi = 1; repeat (3) step();
    rst_req = 1; repeat (8) step();
    last = 1; wact = 1;
    step();
    chk("R11 take masked in reset", take, 1'b0);
    chk("R11 stall masked in reset", stall, 1'b0);
    rst_req = 0; repeat (4) step();
    chk("R11 nmi pending cleared", take, 1'b0);
    quiet(); repeat (3) step();

    // constrained random traffic
    run = 0;
    for (int i = 0; i < 4000; i++) begin
      if (run > 0) begin rst_req = 1; run--; end
      else begin
        rst_req = 0;
        if ($urandom_range(0, 39) == 0) run = $urandom_range(1, 7);
      end
      if ($urandom_range(0, 5) == 0) nmi = ~nmi;
      if ($urandom_range(0, 3) == 0) irq = ~irq;
      if ($urandom_range(0, 4) == 0) test_n = ~test_n;
      ien  = ($urandom_range(0, 2) != 0);
      last = ($urandom_range(0, 3) == 0);
      wact = ($urandom_range(0, 2) == 0);
      ack  = ($urandom_range(0, 4) == 0);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule